// File: doc/BRIEF.md
# Lock-Gated Double-Buffered Two-Channel PWM

This block produces two pulse outputs from one shared up-counter. Each output has its own pair of compare points. When the count equals the set point, the output's level rises. When the count equals the clear point, the level falls. A period value sets the last count of every cycle. The output polarity and enable bits and a pairing mode shape the final pins.

Software writes all timing and shape values into a staging bank through a valid/ready write port. It may do this at any moment. The live bank that drives the counter and the outputs changes only at a cycle boundary, and it then takes the whole staged set in one step. A lock bit holds the staged set back across any number of boundaries. This lets software stage a multi-register change without a cycle ever running on a mix of old and new values. A run bit starts and stops the counter. Stopping early lets the staged set load at once, and the next start runs a fresh cycle with it.

The write port follows these back-pressure rules. A word is taken on a rising edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is low during reset and rises on the first clock after reset release. The block never lowers it after that, so a writer only has to wait once after reset. The read port is a plain combinational lookup.

Top module: `dbuf_pwm`

## Requirements
- R1: A write is taken when `wr_valid` and `wr_ready` are both high at a rising edge. `wr_ready` is 0 in reset and 1 from the first edge after release. The addresses are: 0 set A, 1 clear A, 2 set B, 3 clear B, 4 period, 5 output configuration, 6 pairing mode, 7 control. The output configuration bits are: bit0 invert A, bit1 invert B, bit2 enable A, bit3 enable B. The mode uses bits 1:0. The control bits are bit0 run and bit1 lock, and both act from the next edge.
- R2: `rd_data` returns, in the same cycle, the last value written to the staged register at `rd_addr`. Configuration is kept as 4 bits, mode as 2 bits and control as 2 bits, each zero-extended.
- R3: While run is 1, the count steps 0, 1, … up to period and then returns to 0, so a cycle lasts period+1 clocks. `cycle_end` is 1 exactly in the clock where the count equals period with run set.
- R4: While running, a channel's raw level becomes 1 after a clock whose count equals its set point. It becomes 0 after a clock whose count equals its clear point, and set wins on a tie. The edge that ends a cycle forces both raw levels to 0. A running, enabled pin shows the raw level XOR its invert bit.
- R5: Staged writes never change the cycle in progress. With lock 0, the staged period, the four compare points, the configuration and the mode all become live together on the edge that ends a cycle. A write taken on that same edge waits for the next boundary.
- R6: While lock is 1, no transfer happens at any boundary, whether the counter is running or stopped.
- R7: Clearing lock while running causes no immediate transfer. The staged set becomes live at the next cycle end.
- R8: While run is 0, the count is held at 0, `cycle_end` is 0, and each pin sits at its invert bit. If lock is 0, the staged set is copied to the live bank every clock. After a restart, the first `cycle_end` comes period clocks after the first clock with count 0.
- R9: Mode 1 drives B's raw level as the inverse of A's raw level. Mode 2 drives B's raw level as a copy of A's. Modes 0 and 3 use B's own compare points.
- R10: After reset, both banks hold zero, run and lock are 0, and both pins, `cycle_end` and all read values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write port accepting |
| wr_addr | input | 3 | Staged register select |
| wr_data | input | CNT_W | Write value |
| rd_addr | input | 3 | Read select |
| rd_data | output | CNT_W | Staged register contents |
| pwm_a | output | 1 | Channel A pin |
| pwm_b | output | 1 | Channel B pin |
| cycle_end | output | 1 | High in the last clock of a cycle |

## Verification
The sharpest collision is a staged write, or a lock release, taken on the very edge where `cycle_end` is high. That edge also commits the staged bank, so the result depends on whether the new word lands before or after the snapshot. The bench provokes this by timing writes to `cycle_end` and by measuring the lengths of the cycles before and after. A cycle-accurate model of the requirements judges every pin in every clock. A second collision is a run-and-unlock write while stopped and locked. The bench checks that this write still starts with the old set for one full cycle.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;

  typedef enum logic [2:0] {
    ADDR_SET_A  = 3'd0,
    ADDR_CLR_A  = 3'd1,
    ADDR_SET_B  = 3'd2,
    ADDR_CLR_B  = 3'd3,
    ADDR_PERIOD = 3'd4,
    ADDR_OUTCFG = 3'd5,
    ADDR_MODE   = 3'd6,
    ADDR_CTRL   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    PAIR_INDEP   = 2'd0,
    PAIR_B_INV   = 2'd1,
    PAIR_B_COPY  = 2'd2,
    PAIR_INDEP_X = 2'd3
  } pair_mode_e;

  localparam int CFG_W   = 4;
  localparam int MODE_W  = 2;
  localparam int NUM_CH  = 2;
  localparam int ADDR_W  = 3;

  localparam int CFG_INV_A = 0;
  localparam int CFG_INV_B = 1;
  localparam int CFG_EN_A  = 2;
  localparam int CFG_EN_B  = 3;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_LOCK = 1;

endpackage

// File: rtl/dbuf_pwm_bank.sv
module dbuf_pwm_bank
  import dbuf_pwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [CNT_W-1:0]              rd_data_o,
  input  logic                          boundary_i,
  output logic                          run_o,
  output logic                          lock_o,
  output logic [CNT_W-1:0]              act_period_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  act_set_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  act_clr_o,
  output logic [CFG_W-1:0]              act_cfg_o,
  output logic [MODE_W-1:0]             act_mode_o
);

  localparam int PAD_CFG  = CNT_W - CFG_W;
  localparam int PAD_MODE = CNT_W - MODE_W;
  localparam int PAD_CTRL = CNT_W - 2;

  logic [NUM_CH-1:0][CNT_W-1:0] stg_set, stg_clr;
  logic [CNT_W-1:0]             stg_period;
  logic [CFG_W-1:0]             stg_cfg;
  logic [MODE_W-1:0]            stg_mode;
  logic                         run_q, lock_q;
  logic                         commit;

  assign commit = boundary_i && !lock_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(2 * c);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(2 * c + 1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_set[c] <= '0;
        stg_clr[c] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == SET_ADDR) stg_set[c] <= wr_data_i;
        if (wr_addr_i == CLR_ADDR) stg_clr[c] <= wr_data_i;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_set_o[c] <= '0;
        act_clr_o[c] <= '0;
      end else if (commit) begin
        act_set_o[c] <= stg_set[c];
        act_clr_o[c] <= stg_clr[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_period <= '0;
      stg_cfg    <= '0;
      stg_mode   <= '0;
      run_q      <= 1'b0;
      lock_q     <= 1'b0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        ADDR_PERIOD: stg_period <= wr_data_i;
        ADDR_OUTCFG: stg_cfg    <= wr_data_i[CFG_W-1:0];
        ADDR_MODE:   stg_mode   <= wr_data_i[MODE_W-1:0];
        ADDR_CTRL: begin
          run_q  <= wr_data_i[CTRL_RUN];
          lock_q <= wr_data_i[CTRL_LOCK];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_period_o <= '0;
      act_cfg_o    <= '0;
      act_mode_o   <= '0;
    end else if (commit) begin
      act_period_o <= stg_period;
      act_cfg_o    <= stg_cfg;
      act_mode_o   <= stg_mode;
    end
  end

  always_comb begin
    case (reg_addr_e'(rd_addr_i))
      ADDR_SET_A:  rd_data_o = stg_set[0];
      ADDR_CLR_A:  rd_data_o = stg_clr[0];
      ADDR_SET_B:  rd_data_o = stg_set[1];
      ADDR_CLR_B:  rd_data_o = stg_clr[1];
      ADDR_PERIOD: rd_data_o = stg_period;
      ADDR_OUTCFG: rd_data_o = {{PAD_CFG{1'b0}}, stg_cfg};
      ADDR_MODE:   rd_data_o = {{PAD_MODE{1'b0}}, stg_mode};
      default:     rd_data_o = {{PAD_CTRL{1'b0}}, lock_q, run_q};
    endcase
  end

  assign run_o  = run_q;
  assign lock_o = lock_q;

  // R6: a held lock freezes the whole live bank
  a_r6_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(act_period_o) && $stable(act_cfg_o) &&
                $stable(act_mode_o) && $stable(act_set_o) && $stable(act_clr_o)));

  // R5: away from a boundary the live bank never moves
  a_r5_hold_midcycle: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> ($stable(act_period_o) && $stable(act_cfg_o) &&
                     $stable(act_mode_o) && $stable(act_set_o) && $stable(act_clr_o)));

endmodule

// File: rtl/dbuf_pwm_counter.sv
module dbuf_pwm_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == period_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || wrap_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R3: the last count of a cycle is followed by count zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));

  // R8: a stopped counter stays at zero
  a_r8_stop_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/dbuf_pwm_chan.sv
module dbuf_pwm_chan #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] set_i,
  input  logic [CNT_W-1:0] clr_i,
  output logic             level_o
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 lvl_q <= 1'b0;
    else if (!run_i || wrap_i)  lvl_q <= 1'b0;
    else if (cnt_i == set_i)    lvl_q <= 1'b1;
    else if (cnt_i == clr_i)    lvl_q <= 1'b0;
  end

  assign level_o = lvl_q;

  // R4: the edge ending a cycle leaves the raw level low
  a_r4_clear_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> !lvl_q);

  // R4: a set hit inside a cycle raises the raw level
  a_r4_set_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !wrap_i && (cnt_i == set_i)) |=> lvl_q);

endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm
  import dbuf_pwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             cycle_end
);

  logic                         rdy_q;
  logic                         run, lock, wrap, boundary;
  logic [CNT_W-1:0]             cnt, act_period;
  logic [NUM_CH-1:0][CNT_W-1:0] act_set, act_clr;
  logic [CFG_W-1:0]             act_cfg;
  logic [MODE_W-1:0]            act_mode;
  logic [NUM_CH-1:0]            lvl;
  logic                         raw_b;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign wr_ready = rdy_q;

  assign boundary = !run || wrap;

  dbuf_pwm_bank #(.CNT_W(CNT_W)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_valid && rdy_q),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .boundary_i   (boundary),
    .run_o        (run),
    .lock_o       (lock),
    .act_period_o (act_period),
    .act_set_o    (act_set),
    .act_clr_o    (act_clr),
    .act_cfg_o    (act_cfg),
    .act_mode_o   (act_mode)
  );

  dbuf_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .period_i (act_period),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dbuf_pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .wrap_i  (wrap),
      .cnt_i   (cnt),
      .set_i   (act_set[c]),
      .clr_i   (act_clr[c]),
      .level_o (lvl[c])
    );
  end

  always_comb begin
    case (pair_mode_e'(act_mode))
      PAIR_B_INV:  raw_b = ~lvl[0];
      PAIR_B_COPY: raw_b = lvl[0];
      default:     raw_b = lvl[1];
    endcase
  end

  assign pwm_a = (run && act_cfg[CFG_EN_A]) ? (lvl[0] ^ act_cfg[CFG_INV_A]) : act_cfg[CFG_INV_A];
  assign pwm_b = (run && act_cfg[CFG_EN_B]) ? (raw_b  ^ act_cfg[CFG_INV_B]) : act_cfg[CFG_INV_B];
  assign cycle_end = wrap;

  // R8: no cycle end is reported while stopped
  a_r8_idle_no_end: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !cycle_end);

  // R1: once raised, ready never drops
  a_r1_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready);

  // R9: inverse pairing gives opposite pins when both are enabled with equal inversion
  a_r9_inverse_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_mode == 2'd1 && act_cfg[CFG_EN_A] && act_cfg[CFG_EN_B] &&
     act_cfg[CFG_INV_A] == act_cfg[CFG_INV_B]) |-> (pwm_a != pwm_b));

  // R6: lock is only changed by a taken control write
  a_r6_lock_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready && wr_addr == 3'd7) |=> $stable(lock));

endmodule

// File: tb/dbuf_pwm_bench.sv
module dbuf_pwm_bench;

  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic          pwm_a, pwm_b, cycle_end;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dbuf_pwm #(.CNT_W(CW)) u_dbuf_pwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .cycle_end (cycle_end)
  );

  // ---------------- requirement model and scoreboard ----------------
  logic [CW-1:0] m_stg [0:6];
  logic [CW-1:0] m_act [0:6];
  logic          m_run, m_lock, m_rdy, m_la, m_lb;
  logic [CW-1:0] m_cnt;
  logic [2:0]    exp_q [$];

  function automatic logic [2:0] model_pins();
    logic ra, rb, ea, eb;
    logic [3:0] cf;
    cf = m_act[5][3:0];
    ra = m_la;
    case (m_act[6][1:0])
      2'd1:    rb = !m_la;
      2'd2:    rb = m_la;
      default: rb = m_lb;
    endcase
    ea = (m_run && cf[2]) ? (ra ^ cf[0]) : cf[0];
    eb = (m_run && cf[3]) ? (rb ^ cf[1]) : cf[1];
    return {ea, eb, m_run && (m_cnt == m_act[4])};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin m_stg[i] = '0; m_act[i] = '0; end
      m_run = 0; m_lock = 0; m_rdy = 0; m_la = 0; m_lb = 0; m_cnt = '0;
    end else begin
      logic wrap, take;
      wrap = m_run && (m_cnt == m_act[4]);
      take = wr_valid && m_rdy;
      if (!m_run) begin
        m_cnt = '0; m_la = 0; m_lb = 0;
        if (!m_lock) for (int i = 0; i < 7; i++) m_act[i] = m_stg[i];
      end else begin
        if (m_cnt == m_act[0]) m_la = 1; else if (m_cnt == m_act[1]) m_la = 0;
        if (m_cnt == m_act[2]) m_lb = 1; else if (m_cnt == m_act[3]) m_lb = 0;
        if (wrap) begin
          m_cnt = '0; m_la = 0; m_lb = 0;
          if (!m_lock) for (int i = 0; i < 7; i++) m_act[i] = m_stg[i];
        end else m_cnt = m_cnt + 1'b1;
      end
      if (take) begin
        if (wr_addr == 3'd7) begin m_run = wr_data[0]; m_lock = wr_data[1]; end
        else if (wr_addr == 3'd5) m_stg[5] = {8'd0, wr_data[3:0]};
        else if (wr_addr == 3'd6) m_stg[6] = {10'd0, wr_data[1:0]};
        else m_stg[wr_addr] = wr_data;
      end
      m_rdy = 1;
    end
    exp_q.push_back(model_pins());
  end

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      e = exp_q.pop_front();
      checks += 3;
      if (pwm_a !== e[2]) begin fails++; $display("FAIL R4 pwm_a got %b exp %b t=%0t", pwm_a, e[2], $time); end
      if (pwm_b !== e[1]) begin fails++; $display("FAIL R4/R9 pwm_b got %b exp %b t=%0t", pwm_b, e[1], $time); end
      if (cycle_end !== e[0]) begin fails++; $display("FAIL R3 cycle_end got %b exp %b t=%0t", cycle_end, e[0], $time); end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic to_eoc(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!cycle_end && n < 5000);
  endtask

  task automatic wait_eoc();
    int k;
    if (!cycle_end) to_eoc(k);
  endtask

  task automatic gap(output int n);
    wait_eoc();
    to_eoc(n);
  endtask

  function automatic void summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n, k;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 pwm_a", pwm_a, 0);
    check("R10 pwm_b", pwm_b, 0);
    check("R10 cycle_end", cycle_end, 0);
    rd_addr = 3'd4; #1;
    check("R10 period readback", rd_data, 0);
    check("R1 ready low in reset", wr_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", wr_ready, 1);

    // R2: staging and readback
    wr(3'd0, 12'd2); wr(3'd1, 12'd6); wr(3'd2, 12'd4); wr(3'd3, 12'd9);
    wr(3'd4, 12'd11); wr(3'd5, 12'hFFC); wr(3'd6, 12'd0);
    rd_addr = 3'd4; #1; check("R2 period", rd_data, 11);
    rd_addr = 3'd5; #1; check("R2 config masked", rd_data, 12);
    rd_addr = 3'd3; #1; check("R2 clear B", rd_data, 9);
    wr(3'd7, 12'd1);
    rd_addr = 3'd7; #1; check("R2 control", rd_data, 1);

    // R3: cycle length
    gap(n); check("R3 cycle length", n, 12);

    // R5: write inside a cycle leaves it unchanged
    wait_eoc(); wr(3'd4, 12'd7); to_eoc(k);
    check("R5 current cycle unchanged", 2 + k, 12);
    gap(n); check("R5 next cycle new", n, 8);

    // R5: write landing on the boundary edge waits a full cycle
    wait_eoc();
    wr_valid = 1'b1; wr_addr = 3'd4; wr_data = 12'd4;
    @(negedge clk); wr_valid = 1'b0;
    to_eoc(k); check("R5 boundary write misses", 1 + k, 8);
    gap(n); check("R5 boundary write later", n, 5);
    wr(3'd4, 12'd7); gap(n); gap(n);

    // R6: locked staging
    wr(3'd7, 12'd3);
    wr(3'd4, 12'd5); wr(3'd5, 12'd13);
    gap(n); check("R6 locked cycle 1", n, 8);
    gap(n); check("R6 locked cycle 2", n, 8);
    rd_addr = 3'd4; #1; check("R2 staged while locked", rd_data, 5);

    // R7: unlock is not immediate
    wait_eoc(); wr(3'd7, 12'd1); to_eoc(k);
    check("R7 no immediate transfer", 2 + k, 8);
    gap(n); check("R7 transfer at next end", n, 6);

    // R4: tie set==clear on A, and pairing modes
    wr(3'd0, 12'd3); wr(3'd1, 12'd3); wr(3'd5, 12'd12);
    gap(n); gap(n);
    wr(3'd0, 12'd1); wr(3'd1, 12'd4);
    wr(3'd6, 12'd1); gap(n); gap(n);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9 inverse pair", pwm_b, !pwm_a);
    end
    wr(3'd6, 12'd2); gap(n); gap(n);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9 copy pair", pwm_b, pwm_a);
    end
    wr(3'd6, 12'd3); gap(n); gap(n);

    // R8: early stop and restart
    wait_eoc(); repeat (2) @(negedge clk);
    wr(3'd7, 12'd0); wr(3'd5, 12'd15);
    @(negedge clk);
    check("R8 stopped no end", cycle_end, 0);
    check("R8 A inactive", pwm_a, 1);
    check("R8 B inactive", pwm_b, 1);
    wr(3'd4, 12'd3); wr(3'd5, 12'd12);
    wr(3'd7, 12'd1); to_eoc(k);
    check("R8 restart first cycle", k, 3);
    gap(n); check("R8 restart steady", n, 4);

    // R6: stopped and locked, then run and unlock together
    wr(3'd7, 12'd2); wr(3'd4, 12'd9);
    repeat (4) @(negedge clk);
    wr(3'd7, 12'd1); to_eoc(k);
    check("R6 stopped lock kept old set", k, 3);
    gap(n); check("R6 new set after release", n, 10);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule